// File: doc/BRIEF.md
# Stereo Attenuation and Output Mixer

This block scales a pair of signed parallel audio samples by a per-channel 8-bit gain code, then sends the scaled pair through a small routing matrix. The matrix picks, for each output on its own, silence, the left channel, the right channel or the mean of the two. One sample pair arrives with each strobe. The processed pair appears on registered outputs one clock later and stays there until the next strobe.

Software writes gain codes into staging inputs. The codes become targets only while a load control is high, so both channels can be retuned together. A common mode feeds the left code to both channels. A soft-mute control walks the active gain down to silence one step per sample. When soft mute is released, the gain climbs back to the target one step per sample.

Three conditions force both outputs to zero:
- a start-up window after reset, or after a rising edge on the restart input;
- a converter-disable control;
- a zero-detect mute, which acts only when its enable and the external zero flag are both high.

Top module: `stereo_atten_mix`

## Requirements
- R1: For a gain code c, the scaled sample is floor((x*c + 128) / 256), which rounds halves toward plus infinity. Code 0x00 gives 0 and code 0xFF passes x unchanged.
- R2: Gain targets are copied from the staging inputs only in cycles where `att_load` is 1. Staging values presented while `att_load` is 0 have no effect on the outputs.
- R3: When `att_common` is 1 during a load, the left staging code becomes the target of both channels.
- R4: The active gain changes only at a strobe. The sample taken at that strobe still uses the level held before it, so a freshly loaded target first affects the following sample.
- R5: While `soft_mute` is 1, each strobe lowers the active gain of both channels by one, stopping at 0x00.
- R6: After `soft_mute` returns to 0, each strobe raises the active gain by one until it reaches the target.
- R7: `mode[1:0]` selects the left output and `mode[3:2]` selects the right output. The codes are 00 = zero, 01 = left, 10 = right, 11 = average. Reset value is 4'b1001.
- R8: The average is floor((L+R)/2), taken over the scaled samples with a guard bit so that it never overflows.
- R9: While `dac_off` is 1, a strobe yields zero on both outputs.
- R10: When `zmute_en` and `zero_flag` are both 1, a strobe yields zero on both outputs. `zero_flag` alone changes nothing.
- R11: For 1024 clock cycles after reset release, and again after each rising edge of `restart_n`, strobes yield zero on both outputs.
- R12: `out_valid` is high exactly in the cycle after a strobe. In that same cycle the outputs take their new values, and out of reset they are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| restart_n | input | 1 | Rising edge starts a new start-up window |
| smp_valid | input | 1 | Sample strobe |
| in_l | input | 24 | Left sample, two's complement |
| in_r | input | 24 | Right sample, two's complement |
| att_l | input | 8 | Left gain staging code |
| att_r | input | 8 | Right gain staging code |
| att_load | input | 1 | Commit staging codes to targets |
| att_common | input | 1 | Left code drives both channels |
| soft_mute | input | 1 | Ramp active gain to zero |
| mode | input | 4 | Output routing code |
| dac_off | input | 1 | Force outputs to zero |
| zmute_en | input | 1 | Enable zero-detect mute |
| zero_flag | input | 1 | External all-zero indication |
| out_valid | output | 1 | Outputs updated this cycle |
| out_l | output | 24 | Left processed sample |
| out_r | output | 24 | Right processed sample |

## Verification
Gain is tried with mid-scale codes on samples of opposite sign, and on small odd samples. Together these separate correct rounding from truncation and expose sign mistakes. Routing uses a left sample and a right sample that differ in value and sign, so every code is visible in the result: a swapped selection, a sum that overflows, or a mean rounded the wrong way each give a different number. Staging patterns present new codes with the load low, then load them, then send a priming strobe. Soft mute is followed strobe by strobe on the way down and on the way back up, which pins the step size and the turnaround.

// File: rtl/sam_pkg.sv
// Shared types for the stereo attenuation and output mixer.
// Assumes: route codes are two bits wide, one field per output.
package sam_pkg;
    typedef enum logic [1:0] {
        ROUTE_ZERO  = 2'b00,
        ROUTE_LEFT  = 2'b01,
        ROUTE_RIGHT = 2'b10,
        ROUTE_MEAN  = 2'b11
    } route_e;

    localparam int NUM_CH = 2;
endpackage

// File: rtl/sam_init_timer.sv
// Start-up window timer. Holds busy high for INIT_CYCLES clocks after reset
// and after every rising edge of restart_n.
// Assumes: restart_n is synchronous to clk.
module sam_init_timer #(
    parameter int INIT_CYCLES = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_n,
    output logic busy
);
    localparam int CW = $clog2(INIT_CYCLES + 1);
    localparam logic [CW-1:0] START = CW'(INIT_CYCLES);

    logic [CW-1:0] cnt;
    logic          restart_q;

    // Remembers the previous restart level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) restart_q <= 1'b1;
        else        restart_q <= restart_n;
    end

    // Reloads on a restart edge, otherwise counts down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)                       cnt <= START;
        else if (restart_n && !restart_q) cnt <= START;
        else if (cnt != '0)               cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);
endmodule

// File: rtl/sam_gain_ctrl.sv
// Gain control: staged targets, common mode, soft-mute ramp down and
// ramp back up. Active levels only move at a sample strobe.
// Assumes: channel 0 is left, channel 1 is right.
module sam_gain_ctrl
    import sam_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      strobe,
    input  logic [AW-1:0]             att_l,
    input  logic [AW-1:0]             att_r,
    input  logic                      att_load,
    input  logic                      att_common,
    input  logic                      soft_mute,
    output logic [NUM_CH-1:0][AW-1:0] act
);
    logic [NUM_CH-1:0][AW-1:0] tgt;
    logic [NUM_CH-1:0]         below;
    logic                      ramp;

    // Commits staging codes to targets while the load control is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt <= '1;
        end else if (att_load) begin
            tgt[0] <= att_l;
            tgt[1] <= att_common ? att_l : att_r;
        end
    end

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        assign below[ch] = (act[ch] < tgt[ch]);

        // Steps the active level at each strobe per mute and ramp state.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                act[ch] <= '1;
            end else if (strobe) begin
                if (soft_mute)
                    act[ch] <= (act[ch] == '0) ? '0 : act[ch] - 1'b1;
                else if (ramp && below[ch])
                    act[ch] <= act[ch] + 1'b1;
                else
                    act[ch] <= tgt[ch];
            end
        end
    end

    // Tracks whether a release ramp is still climbing.
    always_ff @(posedge clk) begin
        if (!rst_n)         ramp <= 1'b0;
        else if (strobe) begin
            if (soft_mute)  ramp <= 1'b1;
            else if (ramp)  ramp <= |below;
        end
    end
endmodule

// File: rtl/sam_scale.sv
// Multiplies a signed sample by code/256 with round-half-up and saturation.
// Code all-ones bypasses the multiplier for exact unity gain.
// Assumes: purely combinational; the caller registers the result.
module sam_scale #(
    parameter int DW = 24,
    parameter int AW = 8
) (
    input  logic signed [DW-1:0] din,
    input  logic        [AW-1:0] code,
    output logic signed [DW-1:0] dout
);
    localparam int PW = DW + AW + 2;
    localparam logic signed [PW-1:0] HALF =
        {{(PW-AW){1'b0}}, 1'b1, {(AW-1){1'b0}}};
    localparam logic signed [PW-1:0] MAXV =
        {{(PW-DW+1){1'b0}}, {(DW-1){1'b1}}};
    localparam logic signed [PW-1:0] MINV =
        {{(PW-DW+1){1'b1}}, {(DW-1){1'b0}}};

    logic signed [PW-1:0] prod, rnd, shf;

    // Forms the rounded, scaled product and clamps it to the sample range.
    always_comb begin
        prod = $signed({{(PW-DW){din[DW-1]}}, din})
             * $signed({{(PW-AW){1'b0}}, code});
        rnd  = prod + HALF;
        shf  = rnd >>> AW;
        if (code == '1)       dout = din;
        else if (shf > MAXV)  dout = MAXV[DW-1:0];
        else if (shf < MINV)  dout = MINV[DW-1:0];
        else                  dout = shf[DW-1:0];
    end
endmodule

// File: rtl/sam_route.sv
// One output of the routing matrix: zero, left, right or floor mean.
// Assumes: mean uses a guard bit so the sum cannot wrap.
module sam_route
    import sam_pkg::*;
#(
    parameter int DW = 24
) (
    input  logic [1:0]           sel,
    input  logic signed [DW-1:0] l,
    input  logic signed [DW-1:0] r,
    output logic signed [DW-1:0] dout
);
    logic signed [DW:0] sum;

    // Selects the source named by the two-bit route code.
    always_comb begin
        sum = $signed({l[DW-1], l}) + $signed({r[DW-1], r});
        unique case (route_e'(sel))
            ROUTE_ZERO:  dout = '0;
            ROUTE_LEFT:  dout = l;
            ROUTE_RIGHT: dout = r;
            ROUTE_MEAN:  dout = sum[DW:1];
            default:     dout = '0;
        endcase
    end
endmodule

// File: rtl/stereo_atten_mix.sv
// Top level: gain control, per-channel scaling, routing, forced-zero
// conditions and the output register.
// Assumes: one sample pair per smp_valid; all inputs synchronous to clk.
module stereo_atten_mix
    import sam_pkg::*;
#(
    parameter int DW          = 24,
    parameter int AW          = 8,
    parameter int INIT_CYCLES = 1024
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 restart_n,
    input  logic                 smp_valid,
    input  logic signed [DW-1:0] in_l,
    input  logic signed [DW-1:0] in_r,
    input  logic [AW-1:0]        att_l,
    input  logic [AW-1:0]        att_r,
    input  logic                 att_load,
    input  logic                 att_common,
    input  logic                 soft_mute,
    input  logic [3:0]           mode,
    input  logic                 dac_off,
    input  logic                 zmute_en,
    input  logic                 zero_flag,
    output logic                 out_valid,
    output logic signed [DW-1:0] out_l,
    output logic signed [DW-1:0] out_r
);
    logic [NUM_CH-1:0][AW-1:0]  act;
    logic [NUM_CH-1:0][DW-1:0]  scaled;
    logic [NUM_CH-1:0][DW-1:0]  routed;
    logic [NUM_CH-1:0][DW-1:0]  samp;
    logic                       init_busy;
    logic                       force_zero;

    assign samp[0] = in_l;
    assign samp[1] = in_r;

    sam_init_timer #(.INIT_CYCLES(INIT_CYCLES)) u_init (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_n (restart_n),
        .busy      (init_busy)
    );

    sam_gain_ctrl #(.AW(AW)) u_gain (
        .clk        (clk),
        .rst_n      (rst_n),
        .strobe     (smp_valid),
        .att_l      (att_l),
        .att_r      (att_r),
        .att_load   (att_load),
        .att_common (att_common),
        .soft_mute  (soft_mute),
        .act        (act)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_path
        sam_scale #(.DW(DW), .AW(AW)) u_scale (
            .din  (samp[ch]),
            .code (act[ch]),
            .dout (scaled[ch])
        );
        sam_route #(.DW(DW)) u_route (
            .sel  (mode[2*ch +: 2]),
            .l    (scaled[0]),
            .r    (scaled[1]),
            .dout (routed[ch])
        );
    end

    assign force_zero = init_busy | dac_off | (zmute_en & zero_flag);

    // Registers the processed pair at each strobe and flags it valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_l     <= '0;
            out_r     <= '0;
        end else begin
            out_valid <= smp_valid;
            if (smp_valid) begin
                out_l <= force_zero ? '0 : routed[0];
                out_r <= force_zero ? '0 : routed[1];
            end
        end
    end
endmodule

// File: rtl/sam_checker.sv
// Property checker for stereo_atten_mix, attached by bind below.
// Assumes: act levels and init_busy are visible from the bound scope.
module sam_checker #(
    parameter int DW = 24,
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          smp_valid,
    input logic [3:0]    mode,
    input logic          dac_off,
    input logic          zmute_en,
    input logic          zero_flag,
    input logic          soft_mute,
    input logic          init_busy,
    input logic [AW-1:0] act_l,
    input logic [AW-1:0] act_r,
    input logic          out_valid,
    input logic [DW-1:0] out_l,
    input logic [DW-1:0] out_r
);
    // R4: active gain does not move between strobes
    a_r4_gain_at_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> ($stable(act_l) && $stable(act_r)));

    // R5: soft mute steps the left level down by exactly one
    a_r5_mute_step: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && soft_mute && act_l != '0) |=> (act_l == $past(act_l) - 1'b1));

    // R7: a zero route code silences the left output
    a_r7_route_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && mode[1:0] == 2'b00) |=> (out_l == '0));

    // R9: converter disable forces both outputs to zero
    a_r9_dac_off: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && dac_off) |=> (out_l == '0 && out_r == '0));

    // R10: enabled zero-detect mute forces both outputs to zero
    a_r10_zero_mute: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && zmute_en && zero_flag) |=> (out_l == '0 && out_r == '0));

    // R11: start-up window forces both outputs to zero
    a_r11_init_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && init_busy) |=> (out_l == '0 && out_r == '0));

    // R12: out_valid follows the strobe by one cycle
    a_r12_valid_follow: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |=> out_valid);
    a_r12_valid_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> !out_valid);
endmodule

bind stereo_atten_mix sam_checker #(.DW(DW), .AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_valid (smp_valid),
    .mode      (mode),
    .dac_off   (dac_off),
    .zmute_en  (zmute_en),
    .zero_flag (zero_flag),
    .soft_mute (soft_mute),
    .init_busy (init_busy),
    .act_l     (act[0]),
    .act_r     (act[1]),
    .out_valid (out_valid),
    .out_l     (out_l),
    .out_r     (out_r)
);

// File: tb/tb_stereo_atten_mix.sv
// Directed bench for stereo_atten_mix: one task per scenario.
module tb_stereo_atten_mix;
    localparam int DW = 24;
    localparam int AW = 8;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 restart_n = 1'b1;
    logic                 smp_valid = 1'b0;
    logic signed [DW-1:0] in_l = '0;
    logic signed [DW-1:0] in_r = '0;
    logic [AW-1:0]        att_l = 8'hFF;
    logic [AW-1:0]        att_r = 8'hFF;
    logic                 att_load = 1'b0;
    logic                 att_common = 1'b0;
    logic                 soft_mute = 1'b0;
    logic [3:0]           mode = 4'b1001;
    logic                 dac_off = 1'b0;
    logic                 zmute_en = 1'b0;
    logic                 zero_flag = 1'b0;
    logic                 out_valid;
    logic signed [DW-1:0] out_l;
    logic signed [DW-1:0] out_r;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 1'b0;

    always #2 clk = ~clk;

    stereo_atten_mix dut (
        .clk(clk), .rst_n(rst_n), .restart_n(restart_n), .smp_valid(smp_valid),
        .in_l(in_l), .in_r(in_r), .att_l(att_l), .att_r(att_r),
        .att_load(att_load), .att_common(att_common), .soft_mute(soft_mute),
        .mode(mode), .dac_off(dac_off), .zmute_en(zmute_en), .zero_flag(zero_flag),
        .out_valid(out_valid), .out_l(out_l), .out_r(out_r)
    );

    function automatic int gain_ref(input int x, input int c);
        longint p;
        if (c == 255) return x;
        p = longint'(x) * c + 128;
        return int'(p >>> 8);
    endfunction

    function automatic int mean_ref(input int a, input int b);
        longint s = longint'(a) + longint'(b);
        return int'(s >>> 1);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic strobe(input int l, input int r);
        @(negedge clk);
        in_l = DW'(l);
        in_r = DW'(r);
        smp_valid = 1'b1;
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    task automatic load(input int l, input int r, input bit common);
        @(negedge clk);
        att_l = AW'(l);
        att_r = AW'(r);
        att_common = common;
        att_load = 1'b1;
        @(negedge clk);
        att_load = 1'b0;
        att_common = 1'b0;
    endtask

    task automatic t_reset_and_init();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R12 reset out_valid", int'(out_valid), 0);
        check("R12 reset out_l", int'(out_l), 0);
        strobe(1000, 2000);
        check("R11 init window left", int'(out_l), 0);
        check("R11 init window right", int'(out_r), 0);
        check("R12 valid after strobe", int'(out_valid), 1);
        @(negedge clk);
        check("R12 valid drops", int'(out_valid), 0);
        repeat (1100) @(negedge clk);
        strobe(1000, -2000);
        check("R1 unity left", int'(out_l), 1000);
        check("R1 unity right", int'(out_r), -2000);
    endtask

    task automatic t_gain();
        load(8'h80, 8'h40, 1'b0);
        strobe(400, 400);
        check("R4 prime uses old level", int'(out_l), 400);
        strobe(32'h100000, -32'h100000);
        check("R1 half gain left", int'(out_l), gain_ref(32'h100000, 8'h80));
        check("R1 quarter gain right", int'(out_r), gain_ref(-32'h100000, 8'h40));
        strobe(3, -3);
        check("R1 round half up left", int'(out_l), 2);
        check("R1 round half up right", int'(out_r), gain_ref(-3, 8'h40));
        load(8'h00, 8'hFF, 1'b0);
        strobe(0, 0);
        strobe(5000, 5000);
        check("R1 code zero", int'(out_l), 0);
        check("R1 code ff", int'(out_r), 5000);
    endtask

    task automatic t_staging_ignored();
        load(8'h80, 8'h80, 1'b0);
        strobe(0, 0);
        @(negedge clk);
        att_l = 8'h10;
        att_r = 8'h10;
        strobe(8000, 8000);
        strobe(8000, 8000);
        check("R2 no load left", int'(out_l), 4000);
        check("R2 no load right", int'(out_r), 4000);
    endtask

    task automatic t_common();
        load(8'h40, 8'hC0, 1'b1);
        strobe(0, 0);
        strobe(40000, -40000);
        check("R3 common left", int'(out_l), gain_ref(40000, 8'h40));
        check("R3 common right", int'(out_r), gain_ref(-40000, 8'h40));
    endtask

    task automatic t_soft_mute();
        load(8'h80, 8'h80, 1'b0);
        strobe(0, 0);
        @(negedge clk);
        soft_mute = 1'b1;
        strobe(32'h100000, 32'h100000);
        strobe(32'h100000, 32'h100000);
        strobe(32'h100000, 32'h100000);
        check("R5 third mute step", int'(out_l), gain_ref(32'h100000, 8'h7E));
        for (int i = 0; i < 140; i++) strobe(32'h100000, 32'h100000);
        check("R5 reaches silence", int'(out_r), 0);
        @(negedge clk);
        soft_mute = 1'b0;
        strobe(32'h100000, 32'h100000);
        check("R6 release starts at zero", int'(out_l), 0);
        strobe(32'h100000, 32'h100000);
        check("R6 first up step", int'(out_l), gain_ref(32'h100000, 1));
        strobe(32'h100000, 32'h100000);
        check("R6 second up step", int'(out_r), gain_ref(32'h100000, 2));
        for (int i = 0; i < 140; i++) strobe(32'h100000, 32'h100000);
        check("R6 settles at target", int'(out_l), gain_ref(32'h100000, 8'h80));
    endtask

    task automatic t_modes();
        load(8'hFF, 8'hFF, 1'b0);
        strobe(0, 0);
        @(negedge clk); mode = 4'b0110;
        strobe(1000, -3001);
        check("R7 reverse left", int'(out_l), -3001);
        check("R7 reverse right", int'(out_r), 1000);
        @(negedge clk); mode = 4'b1111;
        strobe(1000, -3001);
        check("R8 mean floor", int'(out_l), mean_ref(1000, -3001));
        strobe(32'h7FFFFF, 32'h7FFFFF);
        check("R8 mean no overflow", int'(out_r), 32'h7FFFFF);
        @(negedge clk); mode = 4'b0000;
        strobe(1000, -3001);
        check("R7 both zero", int'(out_l) | int'(out_r), 0);
        @(negedge clk); mode = 4'b0111;
        strobe(1000, -3001);
        check("R7 left mean", int'(out_l), mean_ref(1000, -3001));
        check("R7 right from left", int'(out_r), 1000);
        @(negedge clk); mode = 4'b1001;
    endtask

    task automatic t_forced_zero();
        @(negedge clk); dac_off = 1'b1;
        strobe(700, 700);
        check("R9 disable left", int'(out_l), 0);
        check("R9 disable right", int'(out_r), 0);
        @(negedge clk); dac_off = 1'b0; zero_flag = 1'b1;
        strobe(700, 800);
        check("R10 flag without enable", int'(out_r), 800);
        @(negedge clk); zmute_en = 1'b1;
        strobe(700, 800);
        check("R10 enabled mute", int'(out_l) | int'(out_r), 0);
        @(negedge clk); zero_flag = 1'b0;
        strobe(700, 800);
        check("R10 enable without flag", int'(out_l), 700);
        @(negedge clk); zmute_en = 1'b0;
    endtask

    task automatic t_restart();
        @(negedge clk); restart_n = 1'b0;
        @(negedge clk); restart_n = 1'b1;
        repeat (10) @(negedge clk);
        strobe(900, 900);
        check("R11 restart window", int'(out_l), 0);
        repeat (1100) @(negedge clk);
        strobe(900, 900);
        check("R11 after restart window", int'(out_l), 900);
    endtask

    initial begin
        t_reset_and_init();
        t_gain();
        t_staging_ignored();
        t_common();
        t_soft_mute();
        t_modes();
        t_forced_zero();
        t_restart();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end
endmodule